// File: doc/BRIEF.md
# I2C Master Buffer-Pool Burst Engine

This block drives the multi-byte burst mode of an I2C master. Software first places bytes in a small shared byte RAM. It then programs a pool control word that gives the number of bytes to transmit and the number to receive. A single command write then starts the burst. The engine walks the bus's own slice of that RAM one byte at a time. It hands each byte to the byte-level bus engine over a request/done handshake and waits for that byte's completion before it moves to the next index.

The engine can take the first pool byte as the address byte of a START condition. It then continues with data from the next index. It stops a transmit burst at the first byte that is answered with NAK. Received bytes are stored from the start of the slice, and the number received is written into the top byte of the pool control word. Software keeps ownership of the lower 24 bits of that word.

Top module: `i2c_pool_engine`

## Requirements
- R1: After reset, the pool control word and the command word read zero, and the engine is idle with no bus request and no RAM access.
- R2: A software write to the pool control word (select 0) changes bits 23:0 only. Bits 31:24 change only when the engine records a receive count.
- R3: The transmit count is bits 15:8 plus one and the receive count is bits 23:16 plus one. Both counts are limited to SLICE_BYTES and are sampled when the command is accepted.
- R4: A command (select 1) with START (bit 0) and transmit-buffer enable (bit 6) first issues a START request (op 0) that carries the byte at slice index 0.
- R5: With START and the transmit flag (bit 1), data bytes go out as TX requests (op 1) from index 1 up to count-1. A transmit count of one sends the address only.
- R6: Without START, a transmit burst sends indices 0 up to count-1 in increasing order. The first NAK on a START or TX byte ends the whole command and sets nak_o.
- R7: A receive burst (bit 3 or the last-flag bit 4, together with receive-buffer enable bit 7) issues RX requests (op 2). It stores the bytes at indices 0 up to count-1, flags the final request as last only when bit 4 is set, and then writes the count into bits 31:24.
- R8: When a command completes, the action bits 0, 1, 3 and 4 and the buffer enables 6 and 7 read back as zero. The other command bits are kept.
- R9: A command that sets bit 6 or 7 while the global SRAM enable (select 2, bit 0) is clear is rejected. It produces a one-cycle rejected_o, has no bus or RAM activity, and leaves the command word unchanged.
- R10: Every RAM access lies within the slice that starts at BUS_ID*SLICE_BYTES and holds SLICE_BYTES bytes.
- R11: One bus request is outstanding at a time, and it holds its op and byte until done. A command write while the engine is busy has no effect.
- R12: A software pool write in the same cycle as the engine's count write-back keeps both: new bits 23:0 and the engine's bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 pool control, 1 command, 2 global |
| reg_wdata_i | input | 32 | Register write data |
| pool_ctrl_o | output | 32 | Pool control word |
| cmd_o | output | 16 | Command word |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse when a command completes |
| nak_o | output | 1 | Last command ended on a NAK |
| rejected_o | output | 1 | One-cycle pulse on a rejected command |
| ram_re_o | output | 1 | RAM read strobe, data valid next cycle |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | RAM_AW | RAM byte address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |
| be_req_o | output | 1 | Byte request to the bus engine |
| be_op_o | output | 2 | Request op: 0 START, 1 TX, 2 RX |
| be_wdata_o | output | 8 | Byte to send |
| be_last_o | output | 1 | RX byte is the last one, answer NAK |
| be_done_i | input | 1 | Bus engine completed the request |
| be_nak_i | input | 1 | Sent byte answered NAK |
| be_rdata_i | input | 8 | Received byte |

## Verification
The engine's receive-count write-back and a software write to the pool control word can land on the same clock edge, and each owns a different part of the same register. The bench waits for the completion pulse of a receive burst and writes new lower bits to the pool control word in that same cycle. It then requires the register to hold both the fresh lower 24 bits and the engine's count in the top byte. A command write injected while a burst is running is the second collision, and it is judged by the unchanged request log and command readback.

// File: rtl/i2c_pool_pkg.sv
package i2c_pool_pkg;
  localparam logic [1:0] SEL_POOL   = 2'd0;
  localparam logic [1:0] SEL_CMD    = 2'd1;
  localparam logic [1:0] SEL_GLOBAL = 2'd2;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_TX    = 2'd1;
  localparam logic [1:0] OP_RX    = 2'd2;

  localparam int CMD_START = 0;
  localparam int CMD_TX    = 1;
  localparam int CMD_RX    = 3;
  localparam int CMD_LAST  = 4;
  localparam int CMD_TXBUF = 6;
  localparam int CMD_RXBUF = 7;

  localparam logic [15:0] CMD_CLR_MASK = 16'h00DB;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_LAT,
    ST_SEND,
    ST_RECV,
    ST_WR,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/i2c_pool_clamp.sv
module i2c_pool_clamp #(
  parameter int SLICE_BYTES = 16,
  parameter int CNT_W       = 5
) (
  input  logic [7:0]       field_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [8:0] raw;
  assign raw = {1'b0, field_i} + 9'd1;

  always_comb begin
    if (raw > 9'(SLICE_BYTES)) cnt_o = CNT_W'(SLICE_BYTES);
    else                       cnt_o = raw[CNT_W-1:0];
  end
endmodule

// File: rtl/i2c_pool_ctrl_reg.sv
module i2c_pool_ctrl_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pool_we_i,
  input  logic        glb_we_i,
  input  logic [31:0] wdata_i,
  input  logic        wb_en_i,
  input  logic [7:0]  wb_cnt_i,
  output logic [31:0] pool_ctrl_o,
  output logic        sram_en_o
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[31:24];

  // software owns 23:0, engine owns 31:24; both may update in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pool_ctrl_o <= '0;
      sram_en_o   <= 1'b0;
    end else begin
      if (pool_we_i) pool_ctrl_o[23:0]  <= wdata_i[23:0];
      if (wb_en_i)   pool_ctrl_o[31:24] <= wb_cnt_i;
      if (glb_we_i)  sram_en_o          <= wdata_i[0];
    end
  end
endmodule

// File: rtl/i2c_pool_seq.sv
module i2c_pool_seq
  import i2c_pool_pkg::*;
#(
  parameter int SLICE_BYTES = 16,
  parameter int BUS_ID      = 2,
  parameter int CNT_W       = 5,
  parameter int RAM_AW      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [15:0]       cmd_wdata_i,
  input  logic              sram_en_i,
  input  logic [CNT_W-1:0]  tx_cnt_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  input  logic [7:0]        ram_rdata_i,
  input  logic              be_done_i,
  input  logic              be_nak_i,
  input  logic [7:0]        be_rdata_i,
  output logic [15:0]       cmd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              nak_o,
  output logic              rejected_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              be_req_o,
  output logic [1:0]        be_op_o,
  output logic [7:0]        be_wdata_o,
  output logic              be_last_o,
  output logic              wb_en_o,
  output logic [7:0]        wb_cnt_o
);
  localparam int IDX_W = $clog2(SLICE_BYTES);
  localparam logic [RAM_AW-1:0] BASE = RAM_AW'(BUS_ID * SLICE_BYTES);

  seq_state_e       state_q;
  logic [15:0]      cmd_q;
  logic [CNT_W-1:0] tx_cnt_q, rx_cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       byte_q;
  logic             addr_phase_q, rx_ran_q, nak_q, rej_q;

  function automatic logic want_rx(input logic [15:0] c);
    return (c[CMD_RX] | c[CMD_LAST]) & c[CMD_RXBUF];
  endfunction

  logic idle, has_buf, accept, reject, last_tx, last_rx;
  assign idle    = (state_q == ST_IDLE);
  assign has_buf = |cmd_wdata_i[CMD_RXBUF:CMD_TXBUF];
  assign accept  = cmd_we_i & idle & has_buf & sram_en_i;
  assign reject  = cmd_we_i & idle & has_buf & ~sram_en_i;
  assign last_tx = ({1'b0, idx_q} == tx_cnt_q - CNT_W'(1));
  assign last_rx = ({1'b0, idx_q} == rx_cnt_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cmd_q        <= '0;
      tx_cnt_q     <= '0;
      rx_cnt_q     <= '0;
      idx_q        <= '0;
      byte_q       <= '0;
      addr_phase_q <= 1'b0;
      rx_ran_q     <= 1'b0;
      nak_q        <= 1'b0;
      rej_q        <= 1'b0;
    end else begin
      rej_q <= reject;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cmd_q    <= cmd_wdata_i;
          tx_cnt_q <= tx_cnt_i;
          rx_cnt_q <= rx_cnt_i;
          nak_q    <= 1'b0;
          rx_ran_q <= 1'b0;
          idx_q    <= '0;
          if (cmd_wdata_i[CMD_START] & cmd_wdata_i[CMD_TXBUF]) begin
            addr_phase_q <= 1'b1;
            state_q      <= ST_RD;
          end else if (cmd_wdata_i[CMD_TX] & cmd_wdata_i[CMD_TXBUF]) begin
            addr_phase_q <= 1'b0;
            state_q      <= ST_RD;
          end else begin
            addr_phase_q <= 1'b0;
            state_q      <= want_rx(cmd_wdata_i) ? ST_RECV : ST_FIN;
          end
        end
        ST_RD:  state_q <= ST_LAT;
        ST_LAT: begin
          byte_q  <= ram_rdata_i;
          state_q <= ST_SEND;
        end
        ST_SEND: if (be_done_i) begin
          if (be_nak_i) begin
            nak_q   <= 1'b1;
            state_q <= ST_FIN;
          end else if (addr_phase_q) begin
            addr_phase_q <= 1'b0;
            if (cmd_q[CMD_TX] && tx_cnt_q > CNT_W'(1)) begin
              idx_q   <= IDX_W'(1);
              state_q <= ST_RD;
            end else begin
              idx_q   <= '0;
              state_q <= want_rx(cmd_q) ? ST_RECV : ST_FIN;
            end
          end else if (last_tx) begin
            idx_q   <= '0;
            state_q <= want_rx(cmd_q) ? ST_RECV : ST_FIN;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_RD;
          end
        end
        ST_RECV: if (be_done_i) begin
          byte_q  <= be_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: begin
          if (last_rx) begin
            rx_ran_q <= 1'b1;
            state_q  <= ST_FIN;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_RECV;
          end
        end
        ST_FIN: begin
          cmd_q   <= cmd_q & ~CMD_CLR_MASK;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_o       = cmd_q;
  assign busy_o      = ~idle;
  assign done_o      = (state_q == ST_FIN);
  assign nak_o       = nak_q;
  assign rejected_o  = rej_q;
  assign ram_re_o    = (state_q == ST_RD);
  assign ram_we_o    = (state_q == ST_WR);
  assign ram_addr_o  = BASE + RAM_AW'(idx_q);
  assign ram_wdata_o = byte_q;
  assign be_req_o    = (state_q == ST_SEND) | (state_q == ST_RECV);
  assign be_op_o     = (state_q == ST_SEND) ? (addr_phase_q ? OP_START : OP_TX) : OP_RX;
  assign be_wdata_o  = byte_q;
  assign be_last_o   = (state_q == ST_RECV) & cmd_q[CMD_LAST] & last_rx;
  assign wb_en_o     = done_o & rx_ran_q;
  assign wb_cnt_o    = 8'(rx_cnt_q);
endmodule

// File: rtl/i2c_pool_engine.sv
module i2c_pool_engine
  import i2c_pool_pkg::*;
#(
  parameter int NUM_BUS     = 8,
  parameter int SLICE_BYTES = 16,
  parameter int BUS_ID      = 2,
  localparam int CNT_W      = $clog2(SLICE_BYTES) + 1,
  localparam int RAM_AW     = $clog2(NUM_BUS * SLICE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       pool_ctrl_o,
  output logic [15:0]       cmd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              nak_o,
  output logic              rejected_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              be_req_o,
  output logic [1:0]        be_op_o,
  output logic [7:0]        be_wdata_o,
  output logic              be_last_o,
  input  logic              be_done_i,
  input  logic              be_nak_i,
  input  logic [7:0]        be_rdata_i
);
  logic             sram_en, wb_en;
  logic [7:0]       wb_cnt;
  logic [7:0]       cnt_field [2];
  logic [CNT_W-1:0] cnt       [2];

  assign cnt_field[0] = pool_ctrl_o[15:8];
  assign cnt_field[1] = pool_ctrl_o[23:16];

  for (genvar g = 0; g < 2; g++) begin : g_clamp
    i2c_pool_clamp #(.SLICE_BYTES(SLICE_BYTES), .CNT_W(CNT_W)) u_clamp (
      .field_i(cnt_field[g]),
      .cnt_o  (cnt[g])
    );
  end

  i2c_pool_ctrl_reg u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pool_we_i  (reg_we_i && reg_sel_i == SEL_POOL),
    .glb_we_i   (reg_we_i && reg_sel_i == SEL_GLOBAL),
    .wdata_i    (reg_wdata_i),
    .wb_en_i    (wb_en),
    .wb_cnt_i   (wb_cnt),
    .pool_ctrl_o(pool_ctrl_o),
    .sram_en_o  (sram_en)
  );

  i2c_pool_seq #(
    .SLICE_BYTES(SLICE_BYTES), .BUS_ID(BUS_ID), .CNT_W(CNT_W), .RAM_AW(RAM_AW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (reg_we_i && reg_sel_i == SEL_CMD),
    .cmd_wdata_i(reg_wdata_i[15:0]),
    .sram_en_i  (sram_en),
    .tx_cnt_i   (cnt[0]),
    .rx_cnt_i   (cnt[1]),
    .ram_rdata_i(ram_rdata_i),
    .be_done_i  (be_done_i),
    .be_nak_i   (be_nak_i),
    .be_rdata_i (be_rdata_i),
    .cmd_o      (cmd_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .nak_o      (nak_o),
    .rejected_o (rejected_o),
    .ram_re_o   (ram_re_o),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .ram_wdata_o(ram_wdata_o),
    .be_req_o   (be_req_o),
    .be_op_o    (be_op_o),
    .be_wdata_o (be_wdata_o),
    .be_last_o  (be_last_o),
    .wb_en_o    (wb_en),
    .wb_cnt_o   (wb_cnt)
  );
endmodule

// File: rtl/i2c_pool_engine_chk.sv
module i2c_pool_engine_chk #(
  parameter int SLICE_BYTES = 16,
  parameter int BUS_ID      = 2,
  parameter int RAM_AW      = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              rejected_o,
  input logic [15:0]       cmd_o,
  input logic [31:0]       pool_ctrl_o,
  input logic              ram_re_o,
  input logic              ram_we_o,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic              be_req_o,
  input logic              be_done_i,
  input logic [1:0]        be_op_o,
  input logic [7:0]        be_wdata_o
);
  localparam logic [RAM_AW-1:0] LO = RAM_AW'(BUS_ID * SLICE_BYTES);
  localparam logic [RAM_AW-1:0] HI = RAM_AW'(BUS_ID * SLICE_BYTES + SLICE_BYTES - 1);

  p_hi_owned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(pool_ctrl_o[31:24]));

  p_done_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cmd_o[7:6] == 2'b00) && (cmd_o[4:3] == 2'b00) && (cmd_o[1:0] == 2'b00));

  p_reject_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rejected_o |-> !busy_o && !be_req_o);

  p_in_slice_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re_o || ram_we_o) |-> (ram_addr_o >= LO) && (ram_addr_o <= HI));

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_req_o && !be_done_i) |=> be_req_o && $stable(be_op_o) && $stable(be_wdata_o));

  p_idle_silent_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !be_req_o && !ram_re_o && !ram_we_o);

  p_single_access_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_re_o, ram_we_o, be_req_o}));
endmodule

bind i2c_pool_engine i2c_pool_engine_chk #(
  .SLICE_BYTES(SLICE_BYTES), .BUS_ID(BUS_ID), .RAM_AW(RAM_AW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rejected_o (rejected_o),
  .cmd_o      (cmd_o),
  .pool_ctrl_o(pool_ctrl_o),
  .ram_re_o   (ram_re_o),
  .ram_we_o   (ram_we_o),
  .ram_addr_o (ram_addr_o),
  .be_req_o   (be_req_o),
  .be_done_i  (be_done_i),
  .be_op_o    (be_op_o),
  .be_wdata_o (be_wdata_o)
);

// File: tb/i2c_pool_engine_tb_top.sv
`timescale 1ns/1ps
module i2c_pool_engine_tb_top;
  localparam int SLICE = 16;
  localparam int BID   = 2;
  localparam int BASE  = BID * SLICE;
  localparam int AW    = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] pool_ctrl;
  logic [15:0] cmd;
  logic        busy, done, nak, rejected;
  logic        ram_re, ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        be_req, be_last;
  logic [1:0]  be_op;
  logic [7:0]  be_wdata, be_rdata;
  logic        be_done, be_nak;

  i2c_pool_engine #(.NUM_BUS(8), .SLICE_BYTES(SLICE), .BUS_ID(BID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .pool_ctrl_o(pool_ctrl), .cmd_o(cmd), .busy_o(busy),
    .done_o(done), .nak_o(nak), .rejected_o(rejected), .ram_re_o(ram_re),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata), .be_req_o(be_req), .be_op_o(be_op),
    .be_wdata_o(be_wdata), .be_last_o(be_last), .be_done_i(be_done),
    .be_nak_i(be_nak), .be_rdata_i(be_rdata)
  );

  // byte RAM model
  logic [7:0] mem [128];
  int oob_cnt = 0;
  initial for (int i = 0; i < 128; i++) mem[i] = 8'(i * 13 + 7);
  always @(posedge clk) begin
    if (ram_re) ram_rdata <= mem[ram_addr];
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if ((ram_re || ram_we) && (int'(ram_addr) < BASE || int'(ram_addr) >= BASE + SLICE))
      oob_cnt <= oob_cnt + 1;
  end

  function automatic logic [7:0] rx_pat(input int n);
    return 8'(8'h3C ^ (n * 29));
  endfunction

  // bus engine model with request log
  int lat = 1, nak_abs = -1, log_n = 0, wait_cnt = 0;
  logic [1:0] log_op   [1024];
  logic [7:0] log_byte [1024];
  logic       log_last [1024];
  initial begin be_done = 1'b0; be_nak = 1'b0; be_rdata = '0; end
  always @(posedge clk) begin
    be_done <= 1'b0;
    if (be_req && !be_done) begin
      if (wait_cnt >= lat) begin
        be_done  <= 1'b1;
        be_nak   <= (log_n == nak_abs);
        be_rdata <= rx_pat(log_n);
        log_op[log_n % 1024]   <= be_op;
        log_byte[log_n % 1024] <= be_wdata;
        log_last[log_n % 1024] <= be_last;
        log_n    <= log_n + 1;
        wait_cnt <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  // expected model
  int         e_n;
  logic [1:0] e_op   [64];
  logic [7:0] e_byte [64];
  logic       e_last [64];
  int         e_ridx [64];
  bit         e_nak, e_rxran;
  int         e_rcnt;
  logic [7:0] snap [128];

  task automatic build_exp(input logic [15:0] c, input logic [31:0] p, input int nak_rel,
                           input int lstart);
    int tcnt, rcnt, first;
    bit stop;
    tcnt = int'(p[15:8]) + 1; if (tcnt > SLICE) tcnt = SLICE;
    rcnt = int'(p[23:16]) + 1; if (rcnt > SLICE) rcnt = SLICE;
    e_n = 0; stop = 1'b0; e_rxran = 1'b0; e_rcnt = rcnt;
    if (c[0] && c[6]) begin
      e_op[0] = 2'd0; e_byte[0] = snap[BASE]; e_last[0] = 1'b0; e_n = 1;
      if (nak_rel == 0) stop = 1'b1;
    end
    if (!stop && c[1] && c[6]) begin
      first = c[0] ? 1 : 0;
      for (int i = first; i < tcnt; i++) begin
        e_op[e_n] = 2'd1; e_byte[e_n] = snap[BASE + i]; e_last[e_n] = 1'b0;
        e_n++;
        if (nak_rel == e_n - 1) begin stop = 1'b1; break; end
      end
    end
    if (!stop && (c[3] || c[4]) && c[7]) begin
      for (int i = 0; i < rcnt; i++) begin
        e_op[e_n] = 2'd2; e_byte[e_n] = rx_pat(lstart + e_n);
        e_last[e_n] = c[4] && (i == rcnt - 1); e_ridx[e_n] = i;
        e_n++;
      end
      e_rxran = 1'b1;
    end
    e_nak = stop;
  endtask

  task automatic run_cmd(input logic [15:0] c, input logic [31:0] p, input int nak_rel,
                         input bit same_cyc, input logic [31:0] newp, input bit inject);
    int lstart, cyc;
    logic [7:0] prev_hi;
    logic [23:0] exp_lo;
    string rq;
    reg_wr(2'd0, p);
    prev_hi = pool_ctrl[31:24];
    for (int i = 0; i < 128; i++) snap[i] = mem[i];
    lstart = log_n;
    nak_abs = lstart + nak_rel;
    build_exp(c, p, nak_rel, lstart);
    reg_wr(2'd1, {16'h0, c});
    if (inject && busy) reg_wr(2'd1, 32'h0000_00FF);
    cyc = 0;
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    check(done, "R11", "completion seen", {31'h0, done}, 32'h1);
    if (same_cyc) begin
      reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = newp;
      @(posedge clk); @(negedge clk);
      reg_we = 1'b0;
      exp_lo = newp[23:0];
    end else begin
      @(posedge clk); @(negedge clk);
      exp_lo = p[23:0];
    end
    check(log_n - lstart == e_n, "R6", "request count", 32'(log_n - lstart), 32'(e_n));
    for (int k = 0; k < e_n && k < log_n - lstart; k++) begin
      rq = (e_op[k] == 2'd0) ? "R4" : (e_op[k] == 2'd1) ? "R5" : "R7";
      check(log_op[(lstart + k) % 1024] == e_op[k], rq, "request op",
            32'(log_op[(lstart + k) % 1024]), 32'(e_op[k]));
      if (e_op[k] != 2'd2)
        check(log_byte[(lstart + k) % 1024] == e_byte[k], rq, "sent byte",
              32'(log_byte[(lstart + k) % 1024]), 32'(e_byte[k]));
      else begin
        check(log_last[(lstart + k) % 1024] == e_last[k], "R7", "last flag",
              32'(log_last[(lstart + k) % 1024]), 32'(e_last[k]));
        check(mem[BASE + e_ridx[k]] == e_byte[k], "R7", "stored rx byte",
              32'(mem[BASE + e_ridx[k]]), 32'(e_byte[k]));
      end
    end
    check(pool_ctrl[31:24] == (e_rxran ? 8'(e_rcnt) : prev_hi),
          same_cyc ? "R12" : "R7", "received count",
          32'(pool_ctrl[31:24]), 32'(e_rxran ? 8'(e_rcnt) : prev_hi));
    check(pool_ctrl[23:0] == exp_lo, same_cyc ? "R12" : "R2", "pool low bits",
          32'(pool_ctrl[23:0]), 32'(exp_lo));
    check(cmd == (c & ~16'h00DB), "R8", "command readback", 32'(cmd), 32'(c & ~16'h00DB));
    check(nak == e_nak, "R6", "nak flag", 32'(nak), 32'(e_nak));
    check(!busy, "R11", "idle after done", 32'(busy), 32'h0);
  endtask

  initial begin
    int prev_n;
    logic [15:0] rc;
    logic [31:0] rp;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(pool_ctrl == 32'h0, "R1", "pool after reset", pool_ctrl, 32'h0);
    check(cmd == 16'h0 && !busy && !be_req, "R1", "idle after reset",
          {15'h0, be_req, cmd}, 32'h0);

    // R9: SRAM disabled
    prev_n = log_n;
    reg_wr(2'd1, 32'h0000_00C3);
    check(rejected, "R9", "reject pulse", {31'h0, rejected}, 32'h1);
    repeat (5) @(negedge clk);
    check(!busy && log_n == prev_n && cmd == 16'h0, "R9", "no activity",
          32'(log_n - prev_n), 32'h0);

    reg_wr(2'd2, 32'h1);

    // R2: engine-owned byte not writable
    reg_wr(2'd0, 32'hFF00_0304);
    check(pool_ctrl == 32'h0000_0304, "R2", "sw write of top byte", pool_ctrl, 32'h0000_0304);

    lat = 1;
    run_cmd(16'h0043, 32'h0000_0300, 200, 1'b0, 0, 1'b0);            // R4, R5
    run_cmd(16'h0043, 32'h0000_0000, 200, 1'b0, 0, 1'b0);            // R5 count one
    run_cmd(16'h00CA, 32'h0001_0500, 2,   1'b0, 0, 1'b0);            // R6 nak stops rx too
    run_cmd(16'h00CB, 32'h0002_0200, 0,   1'b0, 0, 1'b0);            // R6 nak on address
    lat = 0;
    run_cmd(16'h0098, 32'h0004_0000, 200, 1'b0, 0, 1'b0);            // R7
    run_cmd(16'h0088, 32'h0002_0000, 200, 1'b0, 0, 1'b0);            // R7 no last
    run_cmd(16'h00CB, 32'h00FF_2800, 200, 1'b0, 0, 1'b0);            // R3 clamp
    run_cmd(16'h0098, 32'h0003_0000, 200, 1'b1, 32'h00AB_CD12, 1'b0); // R12
    lat = 2;
    run_cmd(16'h0342, 32'h0000_0600, 200, 1'b0, 0, 1'b1);            // R11 inject, R8 keeps bits 9:8

    for (int it = 0; it < 22; it++) begin
      rc = 16'($urandom & 32'h1B) | 16'((($urandom % 3) + 1) << 6);
      rp = {8'h0, 8'($urandom % 24), 8'($urandom % 24), 8'h0};
      lat = $urandom % 3;
      run_cmd(rc, rp, ($urandom % 4 == 0) ? int'($urandom % 6) : 200, 1'b0, 0, 1'b0);
    end

    check(oob_cnt == 0, "R10", "accesses outside slice", 32'(oob_cnt), 32'h0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule